// File: doc/BRIEF.md
# External-Device Read Sequencer

This block runs single read cycles against a slow peripheral on an asynchronous-style memory bus. A host offers a 26-bit address with a valid/ready handshake. On the edge that accepts it, the block starts a bus cycle. It raises the chip select and the output enable at their own programmed edge offsets. It captures the 16-bit data bus at a programmed wait-state count, unless the peripheral stretches or shortens the access by pulling its active-low wait line. The captured word goes back to the host as a one-cycle response pulse.

After capture, the block keeps the chip select for a programmed hold time. It keeps the address and the transaction open for a programmed recovery time, so that a slow peripheral can leave the data bus before the next request is taken. The five timing fields are sampled when the request is accepted. The host may change them while a read is in flight without affecting that read.

Edge numbering used below: the accepting edge is edge S, the k-th rising edge after it is S+k, and the data-capture edge is C.

Top module: `ext_read_seq`

## Requirements
- R1: On edge S (req_valid and req_ready both high), bus_addr takes req_addr, bus_rw is high (read), bus_dir_n goes low, and req_ready goes low.
- R2: bus_bufoe_n goes low on edge S only if cfg_buf_en is 1 at that edge. It returns high on edge C, and stays high for the whole read when cfg_buf_en was 0.
- R3: bus_cs_n goes low on edge S+CSD (cfg_cs_dly). A value of zero makes it low on edge S.
- R4: bus_oe_n goes low on edge S+OED (cfg_oe_dly), with zero meaning edge S. It returns high on edge C.
- R5: If bus_wait_n is never sampled low on edges S+1 onward, C = S+RWS (cfg_wait_states, where 0 behaves as 1). On edge C, rsp_valid is high for exactly one cycle and rsp_data holds the bus_data_in value sampled at that edge.
- R6: Once bus_wait_n is sampled low on some edge S+k (k ≥ 1), the wait-state count no longer applies. This holds even when that edge is S+RWS. C is then the edge one after the first later edge that samples bus_wait_n high. A further low sample before capture restarts this rule.
- R7: A chip-select or output-enable offset that is not earlier than C leaves that strobe high for the whole read.
- R8: bus_cs_n returns high on edge C+CSH (cfg_cs_hold), or on C itself when CSH is 0.
- R9: req_ready returns high, and bus_dir_n returns high, on edge C+max(CSH, PRD), where PRD is cfg_recovery. Until then bus_addr stays unchanged, and req_valid is ignored.
- R10: A low rst_n on a rising edge drives req_ready high, all active-low strobes high, and rsp_valid low, even in mid-read.
- R11: The five timing fields are captured on edge S. Changes to them during the read do not alter its timing.
- R12: With RWS=6, PRD=2, and bus_wait_n sampled low only on edge S+3, capture falls on S+5 and req_ready returns on S+7, one edge before the eight that the counts alone would take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host requests a read |
| req_addr | input | 26 | Read address |
| req_ready | output | 1 | Sequencer can accept a request |
| cfg_buf_en | input | 1 | Enables the external buffer output enable |
| cfg_cs_dly | input | 4 | Chip-select offset from start (CSD) |
| cfg_oe_dly | input | 4 | Output-enable offset from start (OED) |
| cfg_wait_states | input | 4 | Capture offset without wait (RWS) |
| cfg_cs_hold | input | 4 | Chip-select hold after capture (CSH) |
| cfg_recovery | input | 4 | Post-read recovery after capture (PRD) |
| bus_addr | output | 26 | Address to the device |
| bus_rw | output | 1 | Read/write line, high for read |
| bus_dir_n | output | 1 | Buffer direction, low while a read is open |
| bus_bufoe_n | output | 1 | Buffer output enable, active low |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Device output enable, active low |
| bus_data_in | input | 16 | Read data from the device |
| bus_wait_n | input | 1 | Wait request from the device, active low |
| rsp_valid | output | 1 | One-cycle pulse with captured data |
| rsp_data | output | 16 | Captured read word |

## Verification
Reads are tried in three groups. Some have the wait line idle, which isolates the fixed wait-state path. Some have a single low burst that starts before the wait-state edge, so the read ends early. Some have bursts that straddle or exceed it, so the read runs long, including a burst that begins exactly on the wait-state edge. Strobe offsets are driven to zero, to values past the capture edge, and to values in between, which separates the "assert on start" case, the normal case, and the "never asserted" case. The hold and recovery fields are set both ways round, so the test shows whether the chip-select release and the return of ready follow their own counts. Reads with the configuration scrambled mid-flight, or with the request held high throughout, expose any timing that is not latched or any request that is taken early.

// File: rtl/ers_pkg.sv
package ers_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACCESS = 2'd1,
        PH_POST   = 2'd2
    } ers_phase_e;

    localparam int unsigned ERS_NUM_FIELDS = 5;
    localparam int unsigned ERS_F_CSD = 0;
    localparam int unsigned ERS_F_OED = 1;
    localparam int unsigned ERS_F_RWS = 2;
    localparam int unsigned ERS_F_CSH = 3;
    localparam int unsigned ERS_F_PRD = 4;

endpackage

// File: rtl/ers_cfg_latch.sv
// Holds the timing fields of the read in flight; loaded on the accepting edge.
module ers_cfg_latch #(
    parameter int unsigned NUM_FIELDS = 5,
    parameter int unsigned FIELD_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [NUM_FIELDS*FIELD_W-1:0] fields_i,
    output logic [NUM_FIELDS*FIELD_W-1:0] fields_o
);

    logic [NUM_FIELDS*FIELD_W-1:0] fields_d, fields_q;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        always_comb begin
            fields_d[g*FIELD_W +: FIELD_W] = load ? fields_i[g*FIELD_W +: FIELD_W]
                                                  : fields_q[g*FIELD_W +: FIELD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fields_q <= '0;
        else        fields_q <= fields_d;
    end

    assign fields_o = fields_q;

endmodule

// File: rtl/ers_wait_track.sv
// Tracks the device wait line during the access phase.
// seen: a low sample has occurred; rel: the line has come back high since.
module ers_wait_track (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic arm,
    input  logic wait_n,
    output logic seen_o,
    output logic rel_o
);

    typedef struct packed {
        logic seen;
        logic rel;
    } wt_state_t;

    wt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (arm) begin
            if (!wait_n) begin
                st_d.seen = 1'b1;
                st_d.rel  = 1'b0;
            end else if (st_q.seen) begin
                st_d.rel  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seen_o = st_q.seen;
    assign rel_o  = st_q.rel;

endmodule

// File: rtl/ext_read_seq.sv
module ext_read_seq #(
    parameter int unsigned ADDR_W  = 26,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    input  logic               cfg_buf_en,
    input  logic [FIELD_W-1:0] cfg_cs_dly,
    input  logic [FIELD_W-1:0] cfg_oe_dly,
    input  logic [FIELD_W-1:0] cfg_wait_states,
    input  logic [FIELD_W-1:0] cfg_cs_hold,
    input  logic [FIELD_W-1:0] cfg_recovery,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic               bus_rw,
    output logic               bus_dir_n,
    output logic               bus_bufoe_n,
    output logic               bus_cs_n,
    output logic               bus_oe_n,
    input  logic [DATA_W-1:0]  bus_data_in,
    input  logic               bus_wait_n,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data
);
    import ers_pkg::*;

    localparam int unsigned CNT_W = FIELD_W + 1;
    localparam int unsigned CFG_W = ERS_NUM_FIELDS * FIELD_W;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        ers_phase_e         phase;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  addr;
        logic               rw;
        logic               dir_n;
        logic               bufoe_n;
        logic               cs_n;
        logic               oe_n;
        logic               ready;
        logic               rsp_valid;
        logic [DATA_W-1:0]  rsp_data;
    } seq_state_t;

    localparam seq_state_t RESET_STATE = '{
        phase:     PH_IDLE,
        cnt:       '0,
        addr:      '0,
        rw:        1'b1,
        dir_n:     1'b1,
        bufoe_n:   1'b1,
        cs_n:      1'b1,
        oe_n:      1'b1,
        ready:     1'b1,
        rsp_valid: 1'b0,
        rsp_data:  '0
    };

    seq_state_t s_d, s_q;

    logic             start;
    logic [CFG_W-1:0] cfg_live, cfg_lat;
    logic             wt_seen, wt_rel;

    // live fields packed by index so the latch can be generic
    assign cfg_live[ERS_F_CSD*FIELD_W +: FIELD_W] = cfg_cs_dly;
    assign cfg_live[ERS_F_OED*FIELD_W +: FIELD_W] = cfg_oe_dly;
    assign cfg_live[ERS_F_RWS*FIELD_W +: FIELD_W] = cfg_wait_states;
    assign cfg_live[ERS_F_CSH*FIELD_W +: FIELD_W] = cfg_cs_hold;
    assign cfg_live[ERS_F_PRD*FIELD_W +: FIELD_W] = cfg_recovery;

    ers_cfg_latch #(
        .NUM_FIELDS (ERS_NUM_FIELDS),
        .FIELD_W    (FIELD_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .fields_i (cfg_live),
        .fields_o (cfg_lat)
    );

    ers_wait_track u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .arm    (s_q.phase == PH_ACCESS),
        .wait_n (bus_wait_n),
        .seen_o (wt_seen),
        .rel_o  (wt_rel)
    );

    logic [CNT_W-1:0] lat_csd, lat_oed, lat_rws, lat_csh, lat_prd;
    assign lat_csd = CNT_W'(cfg_lat[ERS_F_CSD*FIELD_W +: FIELD_W]);
    assign lat_oed = CNT_W'(cfg_lat[ERS_F_OED*FIELD_W +: FIELD_W]);
    assign lat_rws = (cfg_lat[ERS_F_RWS*FIELD_W +: FIELD_W] == '0)
                   ? CNT_ONE : CNT_W'(cfg_lat[ERS_F_RWS*FIELD_W +: FIELD_W]);
    assign lat_csh = CNT_W'(cfg_lat[ERS_F_CSH*FIELD_W +: FIELD_W]);
    assign lat_prd = CNT_W'(cfg_lat[ERS_F_PRD*FIELD_W +: FIELD_W]);

    logic             capture;
    logic [CNT_W-1:0] cnt_inc;
    logic             hold_done;
    logic             post_done;

    assign start   = (s_q.phase == PH_IDLE) && req_valid;
    assign cnt_inc = (s_q.cnt == CNT_MAX) ? s_q.cnt : s_q.cnt + CNT_ONE;

    // capture: a pending wait release wins; otherwise the count applies only
    // while the wait line has never been seen low and is high now
    assign capture = (s_q.phase == PH_ACCESS) &&
                     (wt_rel || (!wt_seen && bus_wait_n && (s_q.cnt == lat_rws)));

    assign hold_done = (s_q.cnt >= lat_csh);
    assign post_done = hold_done && (s_q.cnt >= lat_prd);

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;

        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.phase   = PH_ACCESS;
                    s_d.cnt     = CNT_ONE;
                    s_d.addr    = req_addr;
                    s_d.rw      = 1'b1;
                    s_d.dir_n   = 1'b0;
                    s_d.bufoe_n = !cfg_buf_en;
                    s_d.cs_n    = (cfg_cs_dly != '0);
                    s_d.oe_n    = (cfg_oe_dly != '0);
                    s_d.ready   = 1'b0;
                end
            end

            PH_ACCESS: begin
                if (capture) begin
                    s_d.rsp_valid = 1'b1;
                    s_d.rsp_data  = bus_data_in;
                    s_d.oe_n      = 1'b1;
                    s_d.bufoe_n   = 1'b1;
                    s_d.cnt       = CNT_ONE;
                    if (lat_csh == '0) s_d.cs_n = 1'b1;
                    if ((lat_csh == '0) && (lat_prd == '0)) begin
                        s_d.phase = PH_IDLE;
                        s_d.dir_n = 1'b1;
                        s_d.ready = 1'b1;
                    end else begin
                        s_d.phase = PH_POST;
                    end
                end else begin
                    s_d.cnt = cnt_inc;
                    if (s_q.cnt == lat_csd) s_d.cs_n = 1'b0;
                    if (s_q.cnt == lat_oed) s_d.oe_n = 1'b0;
                end
            end

            PH_POST: begin
                if (hold_done) s_d.cs_n = 1'b1;
                if (post_done) begin
                    s_d.phase = PH_IDLE;
                    s_d.dir_n = 1'b1;
                    s_d.ready = 1'b1;
                end else begin
                    s_d.cnt = cnt_inc;
                end
            end

            default: s_d = RESET_STATE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= RESET_STATE;
        else        s_q <= s_d;
    end

    assign req_ready   = s_q.ready;
    assign bus_addr    = s_q.addr;
    assign bus_rw      = s_q.rw;
    assign bus_dir_n   = s_q.dir_n;
    assign bus_bufoe_n = s_q.bufoe_n;
    assign bus_cs_n    = s_q.cs_n;
    assign bus_oe_n    = s_q.oe_n;
    assign rsp_valid   = s_q.rsp_valid;
    assign rsp_data    = s_q.rsp_data;

endmodule

// File: rtl/ext_read_seq_chk.sv
module ext_read_seq_chk #(
    parameter int unsigned ADDR_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rw,
    input logic              bus_dir_n,
    input logic              bus_bufoe_n,
    input logic              bus_cs_n,
    input logic              bus_oe_n,
    input logic              rsp_valid
);

    a_r1_start_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=>
            (!bus_dir_n && bus_rw && !req_ready && (bus_addr == $past(req_addr))));

    a_r2_bufoe_inside_read: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_bufoe_n |-> !bus_dir_n);

    a_r5_capture_releases: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (bus_oe_n && bus_bufoe_n));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(bus_addr));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs_n && bus_oe_n && bus_bufoe_n && bus_dir_n));

endmodule

bind ext_read_seq ext_read_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_ready   (req_ready),
    .bus_addr    (bus_addr),
    .bus_rw      (bus_rw),
    .bus_dir_n   (bus_dir_n),
    .bus_bufoe_n (bus_bufoe_n),
    .bus_cs_n    (bus_cs_n),
    .bus_oe_n    (bus_oe_n),
    .rsp_valid   (rsp_valid)
);

// File: tb/ext_read_seq_test.sv
module ext_read_seq_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [25:0] req_addr;
    logic        req_ready;
    logic        cfg_buf_en;
    logic [3:0]  cfg_cs_dly, cfg_oe_dly, cfg_wait_states, cfg_cs_hold, cfg_recovery;
    logic [25:0] bus_addr;
    logic        bus_rw, bus_dir_n, bus_bufoe_n, bus_cs_n, bus_oe_n;
    logic [15:0] bus_data_in;
    logic        bus_wait_n;
    logic        rsp_valid;
    logic [15:0] rsp_data;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #10 clk = ~clk;   // 50 MHz

    ext_read_seq uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .cfg_buf_en(cfg_buf_en), .cfg_cs_dly(cfg_cs_dly), .cfg_oe_dly(cfg_oe_dly),
        .cfg_wait_states(cfg_wait_states), .cfg_cs_hold(cfg_cs_hold),
        .cfg_recovery(cfg_recovery),
        .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_dir_n(bus_dir_n),
        .bus_bufoe_n(bus_bufoe_n), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
        .bus_data_in(bus_data_in), .bus_wait_n(bus_wait_n),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish, act=%0d exp<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input string sig, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: act=%0h exp=%0h", tag, sig, act, exp);
        end
    endtask

    // Capture edge offset from the requirements (R5, R6).
    function automatic int calc_cap(input logic [3:0] rws, input logic [63:0] wmask);
        int  eff  = (rws == 0) ? 1 : int'(rws);
        bit  seen = 0;
        bit  rel  = 0;
        for (int k = 1; k < 62; k++) begin
            if (rel) return k;
            if (wmask[k]) begin seen = 1; rel = 0; end
            else if (seen) rel = 1;
            else if (k == eff) return k;
        end
        return 62;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // One read; wmask bit k = wait line low on edge S+k.
    task automatic run_txn(input string tag, input logic [25:0] addr, input bit buf_en,
                           input logic [3:0] csd, input logic [3:0] oed,
                           input logic [3:0] rws, input logic [3:0] csh,
                           input logic [3:0] prd, input logic [63:0] wmask,
                           input bit hold_req, input bit scramble);
        int          cap  = calc_cap(rws, wmask);
        int          endk = cap + max2(int'(csh), int'(prd));
        logic [15:0] dbase = 16'($urandom);
        req_valid = 1'b1; req_addr = addr; cfg_buf_en = buf_en;
        cfg_cs_dly = csd; cfg_oe_dly = oed; cfg_wait_states = rws;
        cfg_cs_hold = csh; cfg_recovery = prd;
        bus_wait_n = 1'b1; bus_data_in = dbase;
        @(posedge clk);
        for (int k = 0; k <= endk; k++) begin
            if (k > 0) @(posedge clk);
            @(negedge clk);
            chk(tag, "R1 bus_rw", 32'(bus_rw), 32'd1);
            chk(tag, "R9 bus_addr", 32'(bus_addr), 32'(addr));
            chk(tag, "R9 bus_dir_n", 32'(bus_dir_n), 32'(!(k < endk)));
            chk(tag, "R9 req_ready", 32'(req_ready), 32'(k == endk));
            chk(tag, "R2 bus_bufoe_n", 32'(bus_bufoe_n), 32'(!(buf_en && k < cap)));
            chk(tag, "R3/R7/R8 bus_cs_n", 32'(bus_cs_n),
                32'(!((int'(csd) < cap) && (k >= int'(csd)) && (k < cap + int'(csh)))));
            chk(tag, "R4/R7 bus_oe_n", 32'(bus_oe_n),
                32'(!((int'(oed) < cap) && (k >= int'(oed)) && (k < cap))));
            chk(tag, "R5/R6 rsp_valid", 32'(rsp_valid), 32'(k == cap));
            if (k == cap)
                chk(tag, "R5 rsp_data", 32'(rsp_data), 32'(dbase ^ 16'(cap)));
            // inputs for edge S+k+1
            req_valid = hold_req && (k < endk);
            req_addr  = ~addr;
            if (scramble) begin
                cfg_cs_dly = 4'($urandom); cfg_oe_dly = 4'($urandom);
                cfg_wait_states = 4'($urandom); cfg_cs_hold = 4'($urandom);
                cfg_recovery = 4'($urandom); cfg_buf_en = 1'($urandom);
            end
            bus_wait_n  = !wmask[k+1];
            bus_data_in = dbase ^ 16'(k + 1);
        end
        bus_wait_n = 1'b1;
        req_valid  = 1'b0;
    endtask

    task automatic chk_idle(input string tag);
        chk(tag, "req_ready", 32'(req_ready), 32'd1);
        chk(tag, "bus_cs_n", 32'(bus_cs_n), 32'd1);
        chk(tag, "bus_oe_n", 32'(bus_oe_n), 32'd1);
        chk(tag, "bus_bufoe_n", 32'(bus_bufoe_n), 32'd1);
        chk(tag, "bus_dir_n", 32'(bus_dir_n), 32'd1);
        chk(tag, "rsp_valid", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0c3a));
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; cfg_buf_en = 1'b0;
        cfg_cs_dly = '0; cfg_oe_dly = '0; cfg_wait_states = '0;
        cfg_cs_hold = '0; cfg_recovery = '0; bus_data_in = '0; bus_wait_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_idle("R10 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R12: worked example, wait low on S+3 only
        run_txn("R12", 26'h1234567, 1, 4'd1, 4'd2, 4'd6, 4'd1, 4'd2, 64'h8, 0, 0);
        // R5 plain count, buffer enabled
        run_txn("R5", 26'h0aaaaaa, 1, 4'd2, 4'd3, 4'd7, 4'd2, 4'd4, 64'h0, 0, 0);
        // R3/R4 zero offsets, R2 buffer disabled
        run_txn("R3/R4", 26'h3ffffff, 0, 4'd0, 4'd0, 4'd3, 4'd1, 4'd1, 64'h0, 0, 0);
        // R7 strobe offsets past the capture edge
        run_txn("R7", 26'h0000001, 1, 4'd9, 4'd5, 4'd5, 4'd3, 4'd0, 64'h0, 0, 0);
        // R5 zero wait-state field acts as one; R8/R9 zero hold and recovery
        run_txn("R5/R8", 26'h2222222, 1, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0, 64'h0, 0, 0);
        // R8 hold longer than recovery
        run_txn("R8/R9", 26'h1555555, 1, 4'd1, 4'd1, 4'd2, 4'd9, 4'd2, 64'h0, 0, 0);
        // R6 wait held past the count: read runs long
        run_txn("R6 long", 26'h0f0f0f0, 1, 4'd1, 4'd2, 4'd3, 4'd1, 4'd1, 64'h1fe, 0, 0);
        // R6 wait first low exactly on the count edge
        run_txn("R6 edge", 26'h0123456, 0, 4'd1, 4'd1, 4'd4, 4'd2, 4'd3, 64'h30, 0, 0);
        // R6 two bursts
        run_txn("R6 twice", 26'h3210fed, 1, 4'd2, 4'd1, 4'd9, 4'd1, 4'd2, 64'h1c6, 0, 0);
        // R11 scrambled config, R9 request held high throughout
        run_txn("R11", 26'h2bcdef0, 1, 4'd3, 4'd4, 4'd8, 4'd2, 4'd5, 64'h0, 1, 1);
        run_txn("R11/R9", 26'h1abcdef, 0, 4'd1, 4'd2, 4'd6, 4'd4, 4'd1, 64'h60, 1, 1);

        // R10: reset in mid-read
        req_valid = 1'b1; req_addr = 26'h0c0ffee; cfg_buf_en = 1'b1;
        cfg_cs_dly = 4'd1; cfg_oe_dly = 4'd1; cfg_wait_states = 4'd12;
        cfg_cs_hold = 4'd3; cfg_recovery = 4'd3;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk_idle("R10 mid-read");
        rst_n = 1'b1;
        @(negedge clk);

        // constrained random reads
        for (int t = 0; t < 40; t++) begin
            logic [63:0] wm = '0;
            if ($urandom_range(1, 0) == 1) begin
                int a = $urandom_range(12, 1);
                int l = $urandom_range(6, 1);
                for (int b = a; b < a + l; b++) wm[b] = 1'b1;
                if ($urandom_range(3, 0) == 0) begin
                    int a2 = a + l + 1 + $urandom_range(3, 0);
                    wm[a2] = 1'b1;
                end
            end
            run_txn("R3/R4/R5/R6 random", 26'($urandom), 1'($urandom),
                    4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
                    4'($urandom), wm, 1'($urandom), 1'($urandom));
            @(negedge clk);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule